// File: doc/BRIEF.md
# Multicycle Load-Store Processor Core

This block is a small 32-bit processor core that runs four kinds of instruction: register-to-register arithmetic and logic, word load, word store and branch-if-equal. It does not finish an instruction in one long cycle. Each instruction is split into one-cycle steps, and each step uses at most one of the large resources: the single memory port, the register file or the single ALU. Values that one step produces and a later step uses are kept in internal registers: the instruction register, two operand latches, the ALU result latch and the memory data latch. A control state machine chooses the work done in each cycle.

The core uses one memory port for both instruction fetch and data access. In a given cycle it drives an address, a read strobe or a write strobe, and write data. The read data must come back in the same cycle, and a write takes effect on the next rising clock edge. The next program counter is computed during fetch. During decode the ALU also computes the branch target, before the instruction type is known, so that a branch can finish in its third cycle. Each kind of instruction therefore takes its own number of cycles.

Top module: `mc_core`

## Requirements
- R1: While `rst_n` is low, and starting in the cycle it goes low, the core presents a read at address 0 with no write. After release it fetches the first instruction from address 0.
- R2: Every fetch reads the instruction at the current program counter. The counter then advances by 4 unless a taken branch replaces it. Instruction fields: opcode [31:26], first source register [25:21], second source or load/store register [20:16], R-type destination [15:11], function [5:0], immediate [15:0].
- R3: Opcode 000000 (R-type) takes 4 cycles, 100011 (load) takes 5, 101011 (store) takes 4 and 000100 (branch-if-equal) takes 3, measured from one fetch to the next.
- R4: An R-type instruction writes to the destination register the result selected by its function code: 100000 add, 100010 subtract (first minus second), 100100 AND, 100101 OR, 100110 XOR.
- R5: A load reads the word at first source + sign-extended immediate and writes it to register [20:16].
- R6: A store writes register [20:16] to address first source + sign-extended immediate. The write strobe is high only in the fourth cycle of a store.
- R7: A branch whose two source registers are equal continues at its own address + 4 + (sign-extended immediate × 4). Otherwise it continues at its own address + 4.
- R8: Register 0 always reads as zero, and any write to it is ignored.
- R9: Any other opcode takes 2 cycles, changes no register and writes no memory.
- R10: Negative immediates are sign-extended for load and store addresses and for branch offsets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously inside the core |
| mem_addr | output | 32 | Byte address for the current memory access |
| mem_re | output | 1 | Read strobe; read data must return in the same cycle |
| mem_we | output | 1 | Write strobe; memory is updated on the next rising edge |
| mem_wdata | output | 32 | Data to write |
| mem_rdata | input | 32 | Data read from memory |

## Verification
The test program runs every instruction kind in sequence. Each fetch address and each fetch-to-fetch interval is compared against a table, which separates the load, store, R-type, branch and no-op paths by their cycle counts. The R-type operands are a positive value, a negative value and a mixed bit pattern, so that add, subtract and the three logic functions each give distinct results. The program has an untaken and a taken branch, with two stores placed in the skipped shadow, and a backward branch, which checks both branch outcomes and a negative offset. Writes to register 0, a store of register 0, and loads and stores with negative offsets test zero-register handling and sign extension.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam int OPC_LSB = 26;
  localparam int RS_LSB  = 21;
  localparam int RT_LSB  = 16;
  localparam int RD_LSB  = 11;
  localparam int IMM_W   = 16;

  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_XOR = 6'b100110;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_DECODE,
    ST_ADDR,
    ST_EXEC_R,
    ST_BRANCH,
    ST_MEM_RD,
    ST_MEM_WR,
    ST_R_WB,
    ST_LD_WB
  } state_t;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_XOR
  } alu_op_t;

  typedef enum logic {
    ASRC_PC,
    ASRC_A
  } asrc_t;

  typedef enum logic [1:0] {
    BSRC_B,
    BSRC_FOUR,
    BSRC_IMM,
    BSRC_IMM_SH
  } bsrc_t;

  typedef struct packed {
    logic    pc_we;
    logic    pc_cond;
    logic    pc_from_latch;
    logic    ir_en;
    logic    ab_en;
    logic    res_en;
    logic    mdr_en;
    logic    mem_re;
    logic    mem_we;
    logic    addr_from_latch;
    logic    rf_we;
    logic    rf_dst_rd;
    logic    rf_from_mdr;
    asrc_t   asrc;
    bsrc_t   bsrc;
    alu_op_t alu_op;
  } ctrl_t;

endpackage

// File: rtl/mc_rst_sync.sv
module mc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32,
  localparam int IDX_W  = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx_a,
  input  logic [IDX_W-1:0]  rd_idx_b,
  output logic [DATA_W-1:0] rd_val_a,
  output logic [DATA_W-1:0] rd_val_b,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_val
);

  // Entry 0 has no storage; it is a hard zero.
  logic [DATA_W-1:0] regs [1:REG_CNT-1];

  always_ff @(posedge clk) begin
    if (wr_en && (wr_idx != '0)) begin
      regs[wr_idx] <= wr_val;
    end
  end

  always_comb begin
    rd_val_a = (rd_idx_a == '0) ? '0 : regs[rd_idx_a];
    rd_val_b = (rd_idx_b == '0) ? '0 : regs[rd_idx_b];
  end

endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  alu_op_t           op,
  output logic [DATA_W-1:0] result,
  output logic              is_zero
);

  always_comb begin
    unique case (op)
      ALU_SUB: result = opa - opb;
      ALU_AND: result = opa & opb;
      ALU_OR:  result = opa | opb;
      ALU_XOR: result = opa ^ opb;
      default: result = opa + opb;
    endcase
  end

  assign is_zero = (result == '0);

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output state_t     state,
  output ctrl_t      ctl
);

  state_t state_q;
  state_t state_d;

  function automatic alu_op_t funct_to_op(input logic [5:0] fn);
    unique case (fn)
      FN_SUB:  return ALU_SUB;
      FN_AND:  return ALU_AND;
      FN_OR:   return ALU_OR;
      FN_XOR:  return ALU_XOR;
      default: return ALU_ADD;
    endcase
  endfunction

  // Next state and per-step control.
  always_comb begin
    ctl     = '0;
    state_d = state_q;
    unique case (state_q)
      ST_FETCH: begin
        ctl.mem_re = 1'b1;
        ctl.ir_en  = 1'b1;
        ctl.asrc   = ASRC_PC;
        ctl.bsrc   = BSRC_FOUR;
        ctl.alu_op = ALU_ADD;
        ctl.pc_we  = 1'b1;
        state_d    = ST_DECODE;
      end
      ST_DECODE: begin
        ctl.ab_en  = 1'b1;
        ctl.asrc   = ASRC_PC;
        ctl.bsrc   = BSRC_IMM_SH;
        ctl.alu_op = ALU_ADD;
        ctl.res_en = 1'b1;
        unique case (opcode)
          OPC_LOAD, OPC_STORE: state_d = ST_ADDR;
          OPC_RTYPE:           state_d = ST_EXEC_R;
          OPC_BEQ:             state_d = ST_BRANCH;
          default:             state_d = ST_FETCH;
        endcase
      end
      ST_ADDR: begin
        ctl.asrc   = ASRC_A;
        ctl.bsrc   = BSRC_IMM;
        ctl.alu_op = ALU_ADD;
        ctl.res_en = 1'b1;
        state_d    = (opcode == OPC_LOAD) ? ST_MEM_RD : ST_MEM_WR;
      end
      ST_EXEC_R: begin
        ctl.asrc   = ASRC_A;
        ctl.bsrc   = BSRC_B;
        ctl.alu_op = funct_to_op(funct);
        ctl.res_en = 1'b1;
        state_d    = ST_R_WB;
      end
      ST_BRANCH: begin
        ctl.asrc          = ASRC_A;
        ctl.bsrc          = BSRC_B;
        ctl.alu_op        = ALU_SUB;
        ctl.pc_cond       = 1'b1;
        ctl.pc_from_latch = 1'b1;
        state_d           = ST_FETCH;
      end
      ST_MEM_RD: begin
        ctl.mem_re          = 1'b1;
        ctl.addr_from_latch = 1'b1;
        ctl.mdr_en          = 1'b1;
        state_d             = ST_LD_WB;
      end
      ST_MEM_WR: begin
        ctl.mem_we          = 1'b1;
        ctl.addr_from_latch = 1'b1;
        state_d             = ST_FETCH;
      end
      ST_R_WB: begin
        ctl.rf_we     = 1'b1;
        ctl.rf_dst_rd = 1'b1;
        state_d       = ST_FETCH;
      end
      ST_LD_WB: begin
        ctl.rf_we       = 1'b1;
        ctl.rf_from_mdr = 1'b1;
        state_d         = ST_FETCH;
      end
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [DATA_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int IDX_W = $clog2(REG_CNT);
  localparam logic [DATA_W-1:0] WORD_STEP = DATA_W'(4);

  logic   rst_n_sync;
  state_t state;
  ctrl_t  ctl;

  logic [DATA_W-1:0] pc_q, ir_q, a_q, b_q, res_q, mdr_q;
  logic [DATA_W-1:0] rf_a, rf_b;
  logic [DATA_W-1:0] alu_a, alu_b, alu_y;
  logic              alu_zero;
  logic [DATA_W-1:0] imm_sx, imm_sx_sh;
  logic [DATA_W-1:0] pc_d;
  logic              pc_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_val;

  mc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_n_sync)
  );

  mc_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .opcode (ir_q[OPC_LSB +: 6]),
    .funct  (ir_q[5:0]),
    .state  (state),
    .ctl    (ctl)
  );

  assign imm_sx    = {{(DATA_W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign imm_sx_sh = {imm_sx[DATA_W-3:0], 2'b00};

  always_comb begin
    alu_a = (ctl.asrc == ASRC_A) ? a_q : pc_q;
    unique case (ctl.bsrc)
      BSRC_FOUR:   alu_b = WORD_STEP;
      BSRC_IMM:    alu_b = imm_sx;
      BSRC_IMM_SH: alu_b = imm_sx_sh;
      default:     alu_b = b_q;
    endcase
  end

  mc_alu #(.DATA_W(DATA_W)) u_alu (
    .opa     (alu_a),
    .opb     (alu_b),
    .op      (ctl.alu_op),
    .result  (alu_y),
    .is_zero (alu_zero)
  );

  mc_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_rf (
    .clk      (clk),
    .rd_idx_a (ir_q[RS_LSB +: IDX_W]),
    .rd_idx_b (ir_q[RT_LSB +: IDX_W]),
    .rd_val_a (rf_a),
    .rd_val_b (rf_b),
    .wr_en    (ctl.rf_we),
    .wr_idx   (wr_idx),
    .wr_val   (wr_val)
  );

  assign wr_idx = ctl.rf_dst_rd ? ir_q[RD_LSB +: IDX_W] : ir_q[RT_LSB +: IDX_W];
  assign wr_val = ctl.rf_from_mdr ? mdr_q : res_q;

  assign pc_en = ctl.pc_we | (ctl.pc_cond & alu_zero);
  assign pc_d  = ctl.pc_from_latch ? res_q : alu_y;

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      pc_q  <= '0;
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
      mdr_q <= '0;
    end else begin
      if (pc_en)      pc_q  <= pc_d;
      if (ctl.ir_en)  ir_q  <= mem_rdata;
      if (ctl.ab_en)  a_q   <= rf_a;
      if (ctl.ab_en)  b_q   <= rf_b;
      if (ctl.res_en) res_q <= alu_y;
      if (ctl.mdr_en) mdr_q <= mem_rdata;
    end
  end

  assign mem_addr  = ctl.addr_from_latch ? res_q : pc_q;
  assign mem_re    = ctl.mem_re;
  assign mem_we    = ctl.mem_we;
  assign mem_wdata = b_q;

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
  import mc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input state_t            state,
  input logic [DATA_W-1:0] pc,
  input logic [DATA_W-1:0] ir,
  input logic [DATA_W-1:0] a,
  input logic [DATA_W-1:0] b,
  input logic              mem_re,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_addr
);

  logic op_known;
  assign op_known = (ir[31:26] == OPC_RTYPE) || (ir[31:26] == OPC_LOAD) ||
                    (ir[31:26] == OPC_STORE) || (ir[31:26] == OPC_BEQ);

  AST_RESET_START: assert property (@(posedge clk)
    $rose(rst_n) |-> (state == ST_FETCH && pc == '0)); // R1

  AST_FETCH_READS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH) |-> (mem_re && !mem_we && mem_addr == pc)); // R2

  AST_PC_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH) |=> (pc == $past(pc) + DATA_W'(4))); // R2

  AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH) |=> (state == ST_DECODE)); // R3

  AST_LOAD_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MEM_RD) |=> (state == ST_LD_WB)); // R5

  AST_WRITE_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (state == ST_MEM_WR && !mem_re)); // R6

  AST_BRANCH_UNTAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BRANCH && a != b) |=> (pc == $past(pc))); // R7

  AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECODE && ir[25:21] == 5'd0) |=> (a == '0)); // R8

  AST_UNKNOWN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECODE && !op_known) |=> (state == ST_FETCH && !mem_we)); // R9

endmodule

bind mc_core mc_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_sync),
  .state    (state),
  .pc       (pc_q),
  .ir       (ir_q),
  .a        (a_q),
  .b        (b_q),
  .mem_re   (mem_re),
  .mem_we   (mem_we),
  .mem_addr (mem_addr)
);

// File: tb/tb_mc_core.sv
`timescale 1ns/1ps
module tb_mc_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_re, mem_we;

  always #2 clk = ~clk;

  mc_core dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  logic [31:0] mem [0:127];
  assign mem_rdata = mem[mem_addr[8:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[8:2]] <= mem_wdata;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] instr;
    logic [7:0]  cyc;
  } vec_t;

  localparam int NV = 23;
  // Program in execution order: address, word, expected cycles.
  localparam vec_t VEC [NV] = '{
    '{32'h00, 32'h8C010100, 8'd5},  // load r1 <- [0x100]
    '{32'h04, 32'h8C020104, 8'd5},  // load r2 <- [0x104]
    '{32'h08, 32'h8C030108, 8'd5},  // load r3 <- [0x108]
    '{32'h0C, 32'h00222020, 8'd4},  // r4 = r1 + r2
    '{32'h10, 32'h00222822, 8'd4},  // r5 = r1 - r2
    '{32'h14, 32'h00623024, 8'd4},  // r6 = r3 & r2
    '{32'h18, 32'h00613825, 8'd4},  // r7 = r3 | r1
    '{32'h1C, 32'h00624026, 8'd4},  // r8 = r3 ^ r2
    '{32'h20, 32'h00210020, 8'd4},  // r0 = r1 + r1 (dropped)
    '{32'h24, 32'hAC040180, 8'd4},  // store r4 -> 0x180
    '{32'h28, 32'hAC050184, 8'd4},
    '{32'h2C, 32'hAC060188, 8'd4},
    '{32'h30, 32'hAC07018C, 8'd4},
    '{32'h34, 32'hAC080190, 8'd4},
    '{32'h38, 32'hAC000194, 8'd4},  // store r0 -> 0x194
    '{32'h3C, 32'h10220005, 8'd3},  // beq r1,r2 untaken
    '{32'h40, 32'h10210002, 8'd3},  // beq r1,r1 taken -> 0x4C
    '{32'h4C, 32'hFC000000, 8'd2},  // unknown opcode
    '{32'h50, 32'h8C09010C, 8'd5},  // load r9 <- [0x10C] = 0x1A0
    '{32'h54, 32'hAD23FFFC, 8'd4},  // store r3 -> r9-4
    '{32'h58, 32'h8D2AFF64, 8'd5},  // load r10 <- [r9-0x9C]
    '{32'h5C, 32'hAC0A01A0, 8'd4},  // store r10 -> 0x1A0
    '{32'h60, 32'h1000FFFF, 8'd3}   // beq r0,r0,-1 -> self
  };

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Fetch trace: a fetch ends in the last cycle of a run of code-region reads.
  logic [31:0] tr_addr [0:63];
  int          tr_cyc  [0:63];
  int          n_tr = 0;
  int          cyc_cnt = 0;
  int          wr_cnt = 0;
  bit          prev_code = 1'b0;
  logic [31:0] prev_addr = '0;

  always @(negedge clk) begin
    bit code_rd;
    code_rd = mem_re && (mem_addr < 32'h100);
    if (rst_n) begin
      if (prev_code && !code_rd && n_tr < 64) begin
        tr_addr[n_tr] = prev_addr;
        tr_cyc[n_tr]  = cyc_cnt - 1;
        n_tr++;
      end
      if (mem_we) wr_cnt++;
    end
    prev_code = code_rd;
    prev_addr = mem_addr;
    cyc_cnt++;
  end

  initial begin
    #80000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic string kind_tag(input logic [31:0] w);
    case (w[31:26])
      6'b100011: return "R5";
      6'b101011: return "R6";
      6'b000100: return "R7";
      6'b000000: return "R4";
      default:   return "R9";
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    mem[64]  = 32'h0000_0007;
    mem[65]  = 32'hFFFF_FFF0;
    mem[66]  = 32'h1234_5678;
    mem[67]  = 32'h0000_01A0;
    mem[101] = 32'hDEAD_BEEF;
    mem[102] = 32'hAAAA_5555;
    for (int i = 0; i < NV; i++) mem[VEC[i].addr[8:2]] = VEC[i].instr;
    mem[17] = 32'hAC010198;  // branch shadow, must not run
    mem[18] = 32'hAC020198;

    // R1: reset state at the ports
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset addr", mem_addr, 32'h0);
    check("R1 reset read", {31'b0, mem_re}, 32'h1);
    check("R1 reset write", {31'b0, mem_we}, 32'h0);
    rst_n = 1'b1;

    repeat (200) @(posedge clk);
    @(negedge clk);

    check("R1 fetch count", {31'b0, (n_tr >= NV + 1)}, 32'h1);
    for (int i = 0; i < NV; i++) begin
      logic [31:0] nxt;
      nxt = (i == NV - 1) ? 32'h60 : VEC[i+1].addr;
      check((i == 0) ? "R1 first fetch" : "R2 fetch addr", tr_addr[i], VEC[i].addr);
      check({"R3 cycles ", kind_tag(VEC[i].instr)},
            32'(tr_cyc[i+1] - tr_cyc[i]), {24'b0, VEC[i].cyc});
      check({(VEC[i].instr[31:26] == 6'b000100) ? "R7" : "R2", " next addr"},
            tr_addr[i+1], nxt);
    end

    // Directed result checks in data memory
    check("R4 add / R10 load", mem[96],  32'hFFFF_FFF7);
    check("R4 sub",            mem[97],  32'h0000_0017);
    check("R4 and",            mem[98],  32'h1234_5670);
    check("R4 or",             mem[99],  32'h1234_567F);
    check("R4 xor",            mem[100], 32'hEDCB_A988);
    check("R8 zero reg",       mem[101], 32'h0000_0000);
    check("R7 shadow skipped", mem[102], 32'hAAAA_5555);
    check("R10 neg store",     mem[103], 32'h1234_5678);
    check("R5 neg load R10",   mem[104], 32'hFFFF_FFF0);
    check("R6 R9 write count", 32'(wr_cnt), 32'd8);

    // R1: reset asserted mid-run takes hold without a clock edge
    #0.5 rst_n = 1'b0;
    #0.5;
    check("R1 async addr", mem_addr, 32'h0);
    check("R1 async read", {31'b0, mem_re}, 32'h1);
    check("R1 async write", {31'b0, mem_we}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule